// File: doc/BRIEF.md
# Dual-Domain Power and Reset Controller

This block sits in the always-on part of a two-radio chip. It decides whether the internal regulators run and releases the core resets for a wireless LAN core, a Bluetooth core, and an FM receiver core that depends on the Bluetooth core. The host drives two active-low power-off pins and two active-low reset pins. An analog detector supplies two supply-good flags, one for the core rail and one for the I/O rail. A free-running slow clock times the internal power-on hold.

All six asynchronous inputs pass through a two-flop synchroniser. The regulator enable is the registered OR of the two synchronised power-off pins. The power-on hold counts a parameterised number of clocks after both supply flags are good. The count starts again from zero whenever either flag drops.

Each core reset is requested when any of these holds: the power-on hold is active, the regulator enable is low, or that core's external reset pin is low. A request drives the reset output low at once. The output is released through a two-stage chain clocked by the local clock. The FM reset follows exactly the same request as the Bluetooth reset.

Top module: `pwrrst_ctrl`

## Requirements
- R1: `reg_en` goes high on the third rising clock edge after either `wl_off_n` or `bt_off_n` goes high. It is high only if at least one of those pins was high three edges earlier.
- R2: `reg_en` stays high while at least one power-off pin is high. It goes low on the third edge after both pins are low.
- R3: Core resets stay low until both supply flags have been good for `POR_CYCLES` consecutive synchronised clocks. With the other conditions met, they go high on edge `POR_CYCLES`+4 after the later flag rises, and not before. One good flag alone never releases them.
- R4: When either supply flag drops, even for a single clock, all core resets go low on the third edge. The full `POR_CYCLES` count then restarts from zero.
- R5: `wl_ext_rst_n` low drives `wl_core_rst_n` low on the second edge and leaves the Bluetooth and FM resets high. After the pin returns high, `wl_core_rst_n` is released on the fourth edge.
- R6: `bt_ext_rst_n` low drives `bt_core_rst_n` and `fm_core_rst_n` low on the second edge and leaves `wl_core_rst_n` high. Both are released on the fourth edge after the pin returns high.
- R7: `fm_core_rst_n` always equals `bt_core_rst_n`.
- R8: While `reg_en` is low, all three core resets are low. They go low on the same edge that `reg_en` falls, and they are released two edges after `reg_en` rises.
- R9: With `rst_n` low, `reg_en` and all core resets are low after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock, also the power-on timer base |
| rst_n | input | 1 | Synchronous active-low reset of the controller itself |
| wl_off_n | input | 1 | Asynchronous, active-low power-off request from the WLAN side |
| bt_off_n | input | 1 | Asynchronous, active-low power-off request from the Bluetooth side |
| wl_ext_rst_n | input | 1 | Asynchronous, active-low external reset for the WLAN core |
| bt_ext_rst_n | input | 1 | Asynchronous, active-low external reset for the Bluetooth and FM cores |
| core_pwr_good | input | 1 | Core supply above threshold (asynchronous) |
| io_pwr_good | input | 1 | I/O supply above threshold (asynchronous) |
| reg_en | output | 1 | Internal regulator enable |
| wl_core_rst_n | output | 1 | Active-low reset for the WLAN core |
| bt_core_rst_n | output | 1 | Active-low reset for the Bluetooth core |
| fm_core_rst_n | output | 1 | Active-low reset for the FM core |

## Verification
The hardest situation to reach from the ports is a supply dip that arrives partway through a power-on count that was itself restarted by an earlier dip. A late restart could then be confused with the first release time. The stimulus drops the I/O flag for a single clock, then drops the core flag for a single clock twelve clocks later. It checks that the resets are still low where the first count would have ended, still low one edge before the second count ends, and high exactly on the edge after that. A second hard case is the regulator turning back on with the power-on hold already complete: the resets must still pass through the release chain, and the bench checks the intermediate edge where `reg_en` is high but every reset is still low.

// File: rtl/pwrrst_pkg.sv
// Package: shared types and constants for the power and reset controller.
// Assumes: one bundle bit per asynchronous pin; all bundle bits reset to 0.
package pwrrst_pkg;

    // Asynchronous pins gathered so that one synchroniser handles them all
    typedef struct packed {
        logic core_good;
        logic io_good;
        logic wl_ext;
        logic bt_ext;
        logic wl_off;
        logic bt_off;
    } pin_bundle_t;

    // Core reset domains, one reset chain each
    localparam int unsigned NUM_DOM = 3;
    localparam int unsigned DOM_WL  = 0;
    localparam int unsigned DOM_BT  = 1;
    localparam int unsigned DOM_FM  = 2;

endpackage

// File: rtl/pwrrst_sync.sv
// Module: multi-bit flop-chain synchroniser for independent asynchronous pins.
// Assumes: each bit is a level that is stable for several clocks, so bits
// need not stay coherent with each other. Synchronous active-low reset loads RST_VAL.
module pwrrst_sync #(
    parameter int unsigned     W       = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] q;
        logic [W-1:0] d;
        if (s == 0) begin : g_in
            assign d = d_i;
        end else begin : g_link
            assign d = g_stage[s-1].q;
        end
        // One register stage of the chain
        always_ff @(posedge clk_i) begin
            if (!rst_ni) q <= RST_VAL;
            else         q <= d;
        end
    end

    assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/pwrrst_por.sv
// Module: power-on hold timer. It counts POR_CYCLES clocks of good supply
// and then raises done_o. Any clock with good_i low clears the count and done_o.
// Assumes: good_i is already synchronised; POR_CYCLES >= 2.
module pwrrst_por #(
    parameter int unsigned POR_CYCLES = 3605
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic good_i,
    output logic done_o
);

    localparam int unsigned CNT_W = (POR_CYCLES > 2) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Count good-supply clocks; restart on any supply loss
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !good_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done_o = done_q;

    AST_POR_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);                                                    // R3
    AST_POR_DONE_NEEDS_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_q) |-> $past(good_i));                                  // R3
    AST_POR_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_q && good_i) |=> done_q);                                    // R3
    AST_POR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !good_i |=> !done_q);                                              // R4

endmodule

// File: rtl/pwrrst_core_rst.sv
// Module: reset chain for one core. A high clr_i drives rst_no low at once,
// without waiting for a clock. Release needs STAGES clock edges with clr_i low.
// Assumes: clr_i comes from registered logic, so it has no glitches. This module
// uses an asynchronous clear by intent; it is the only one that does.
module pwrrst_core_rst #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic clr_i,
    output logic rst_no
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic q;
        logic d;
        if (s == 0) begin : g_in
            assign d = 1'b1;
        end else begin : g_link
            assign d = g_stage[s-1].q;
        end
        // Release stage: cleared at once, set one clock after the previous stage
        always_ff @(posedge clk_i or posedge clr_i) begin
            if (clr_i) q <= 1'b0;
            else       q <= d;
        end
    end

    assign rst_no = g_stage[STAGES-1].q;

endmodule

// File: rtl/pwrrst_ctrl.sv
// Module: top of the power and reset controller. It synchronises the pins,
// forms the regulator enable, times the power-on hold, and drives three core
// reset chains. The FM chain takes the Bluetooth request.
// Assumes: clk runs free whenever this logic is powered; rst_n is synchronous.
module pwrrst_ctrl
    import pwrrst_pkg::*;
#(
    parameter int unsigned POR_CYCLES  = 3605,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RST_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wl_off_n,
    input  logic bt_off_n,
    input  logic wl_ext_rst_n,
    input  logic bt_ext_rst_n,
    input  logic core_pwr_good,
    input  logic io_pwr_good,
    output logic reg_en,
    output logic wl_core_rst_n,
    output logic bt_core_rst_n,
    output logic fm_core_rst_n
);

    localparam int unsigned PIN_W = $bits(pin_bundle_t);

    pin_bundle_t raw_pins;
    pin_bundle_t sync_pins;
    logic        both_good;
    logic        por_done;
    logic        reg_en_q;
    logic        wl_req;
    logic        bt_req;
    logic [NUM_DOM-1:0] req_vec;
    logic [NUM_DOM-1:0] rst_vec;

    // Gather the asynchronous pins into one bundle
    always_comb begin
        raw_pins.core_good = core_pwr_good;
        raw_pins.io_good   = io_pwr_good;
        raw_pins.wl_ext    = wl_ext_rst_n;
        raw_pins.bt_ext    = bt_ext_rst_n;
        raw_pins.wl_off    = wl_off_n;
        raw_pins.bt_off    = bt_off_n;
    end

    pwrrst_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) i_sync (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .d_i    (raw_pins),
        .q_o    (sync_pins)
    );

    assign both_good = sync_pins.core_good & sync_pins.io_good;

    pwrrst_por #(
        .POR_CYCLES (POR_CYCLES)
    ) i_por (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .good_i (both_good),
        .done_o (por_done)
    );

    // Regulators stay on while either side still wants power
    always_ff @(posedge clk) begin
        if (!rst_n) reg_en_q <= 1'b0;
        else        reg_en_q <= sync_pins.wl_off | sync_pins.bt_off;
    end

    // Per-core reset requests
    always_comb begin
        wl_req = ~por_done | ~reg_en_q | ~sync_pins.wl_ext;
        bt_req = ~por_done | ~reg_en_q | ~sync_pins.bt_ext;
        req_vec          = '0;
        req_vec[DOM_WL]  = wl_req;
        req_vec[DOM_BT]  = bt_req;
        req_vec[DOM_FM]  = bt_req;
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pwrrst_core_rst #(
            .STAGES (RST_STAGES)
        ) i_rst (
            .clk_i  (clk),
            .clr_i  (req_vec[d]),
            .rst_no (rst_vec[d])
        );
    end

    assign reg_en        = reg_en_q;
    assign wl_core_rst_n = rst_vec[DOM_WL];
    assign bt_core_rst_n = rst_vec[DOM_BT];
    assign fm_core_rst_n = rst_vec[DOM_FM];

    AST_REG_EN_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> $past(wl_off_n | bt_off_n, SYNC_STAGES + 1));           // R1
    AST_OFF_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> (!wl_core_rst_n && !bt_core_rst_n && !fm_core_rst_n)); // R8
    AST_WL_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pins.wl_ext |-> !wl_core_rst_n);                             // R5
    AST_WL_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wl_core_rst_n) |-> !$past(wl_req));                          // R5
    AST_BT_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pins.bt_ext |-> (!bt_core_rst_n && !fm_core_rst_n));         // R6
    AST_POR_HOLDS_CORES: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |-> (!wl_core_rst_n && !bt_core_rst_n));                 // R3
    AST_FM_MATCHES_BT: assert property (@(posedge clk) disable iff (!rst_n)
        fm_core_rst_n == bt_core_rst_n);                                   // R7

endmodule

// File: tb/test_pwrrst_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver schedules expected output values at absolute
// cycles; a monitor compares them on the falling edge and removes them.
module test_pwrrst_ctrl;

    localparam int unsigned POR = 20;
    localparam logic [3:0] M_REG  = 4'b1000;
    localparam logic [3:0] M_WL   = 4'b0100;
    localparam logic [3:0] M_BT   = 4'b0010;
    localparam logic [3:0] M_FM   = 4'b0001;
    localparam logic [3:0] M_CORE = 4'b0111;
    localparam logic [3:0] M_ALL  = 4'b1111;

    logic clk = 1'b0;
    logic rst_n, wl_off_n, bt_off_n, wl_ext_rst_n, bt_ext_rst_n;
    logic core_pwr_good, io_pwr_good;
    logic reg_en, wl_core_rst_n, bt_core_rst_n, fm_core_rst_n;

    always #2 clk = ~clk;

    pwrrst_ctrl #(.POR_CYCLES(POR)) i_pwrrst_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wl_off_n      (wl_off_n),
        .bt_off_n      (bt_off_n),
        .wl_ext_rst_n  (wl_ext_rst_n),
        .bt_ext_rst_n  (bt_ext_rst_n),
        .core_pwr_good (core_pwr_good),
        .io_pwr_good   (io_pwr_good),
        .reg_en        (reg_en),
        .wl_core_rst_n (wl_core_rst_n),
        .bt_core_rst_n (bt_core_rst_n),
        .fm_core_rst_n (fm_core_rst_n)
    );

    typedef struct {
        int unsigned at;
        logic [3:0]  mask;
        logic [3:0]  val;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;

    always @(posedge clk) cyc++;

    task automatic expect_at(input int unsigned dly, input logic [3:0] mask,
                             input logic [3:0] val, input string tag);
        exp_t e;
        e.at = cyc + dly; e.mask = mask; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due expectations against {reg_en, wl, bt, fm}
    always @(negedge clk) begin
        logic [3:0] obs;
        obs = {reg_en, wl_core_rst_n, bt_core_rst_n, fm_core_rst_n};
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                checks++;
                if ((obs & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
                    errors++;
                    $display("FAIL %s: cycle %0d actual %b expected %b (mask %b)",
                             sb[i].tag, cyc, obs, sb[i].val, sb[i].mask);
                end
                sb.delete(i);
            end
        end
    end

    task automatic run_seq();
        rst_n = 1'b0; wl_off_n = 1'b0; bt_off_n = 1'b0;
        wl_ext_rst_n = 1'b0; bt_ext_rst_n = 1'b0;
        core_pwr_good = 1'b0; io_pwr_good = 1'b0;
        step(3);
        expect_at(1, M_ALL, 4'b0000, "R9 reset state");
        step(2);
        rst_n = 1'b1; wl_ext_rst_n = 1'b1; bt_ext_rst_n = 1'b1; wl_off_n = 1'b1;
        expect_at(2, M_REG, 4'b0000, "R1 enable not yet");
        expect_at(3, M_REG, M_REG,   "R1 enable from one pin");
        expect_at(3, M_CORE, 4'b0000, "R3 no supply holds resets");
        step(5);
        core_pwr_good = 1'b1;
        expect_at(POR + 10, M_CORE, 4'b0000, "R3 one supply only");
        step(POR + 12);
        io_pwr_good = 1'b1;
        expect_at(POR + 3, M_CORE, 4'b0000, "R3 still held one edge early");
        expect_at(POR + 4, M_CORE, M_CORE,  "R3 release after count");
        step(POR + 6);
        // WLAN external reset
        wl_ext_rst_n = 1'b0;
        expect_at(1, M_WL, M_WL, "R5 not yet asserted");
        expect_at(2, M_CORE, 4'b0011, "R5 wl asserted, bt and fm unaffected");
        step(4);
        wl_ext_rst_n = 1'b1;
        expect_at(3, M_WL, 4'b0000, "R5 release not early");
        expect_at(4, M_CORE, M_CORE, "R5 release");
        step(6);
        // Bluetooth external reset also resets FM
        bt_ext_rst_n = 1'b0;
        expect_at(1, M_CORE, M_CORE, "R6 not yet asserted");
        expect_at(2, M_ALL, 4'b1100, "R6 R7 bt and fm asserted, wl unaffected");
        step(4);
        bt_ext_rst_n = 1'b1;
        expect_at(3, M_BT | M_FM, 4'b0000, "R6 release not early");
        expect_at(4, M_CORE, M_CORE, "R6 R7 release");
        step(6);
        // One-clock supply dips, the second during the restarted count
        io_pwr_good = 1'b0;
        expect_at(2, M_CORE, M_CORE,  "R4 before dip reaches logic");
        expect_at(3, M_CORE, 4'b0000, "R4 dip asserts resets");
        step(1);
        io_pwr_good = 1'b1;
        step(11);
        core_pwr_good = 1'b0;
        expect_at(POR + 5 - 12, M_CORE, 4'b0000, "R4 first count was restarted");
        expect_at(POR + 4, M_CORE, 4'b0000, "R4 held one edge early");
        expect_at(POR + 5, M_CORE, M_CORE,  "R4 release after full recount");
        step(1);
        core_pwr_good = 1'b1;
        step(POR + 8);
        // Regulator enable from either pin
        bt_off_n = 1'b1;
        step(4);
        wl_off_n = 1'b0;
        expect_at(4, M_ALL, M_ALL, "R2 one pin high keeps power");
        step(6);
        bt_off_n = 1'b0;
        expect_at(2, M_ALL, M_ALL,   "R8 before enable drops");
        expect_at(3, M_ALL, 4'b0000, "R2 R8 both low disable and reset");
        step(6);
        wl_off_n = 1'b1;
        expect_at(3, M_ALL, M_REG,   "R8 enable back, resets held");
        expect_at(4, M_CORE, 4'b0000, "R8 release chain in progress");
        expect_at(5, M_ALL, M_ALL,   "R8 released");
        step(8);
        // Controller reset in operation
        rst_n = 1'b0;
        expect_at(1, M_ALL, 4'b0000, "R9 reset in operation");
        step(3);
        rst_n = 1'b1;
        step(4);
    endtask

    initial begin
        fork
            run_seq();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        disable fork;
        if (sb.size() != 0) begin
            errors += sb.size();
            $display("FAIL pending: %0d expectations never compared (expected 0)", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule